// File: doc/BRIEF.md
# Checkpointed Rename Map with Single-Cycle Recovery

This block holds the register rename map of an out-of-order core together with the free set of physical tags, and adds a small pool of shadow copies of that map. One instruction is renamed per cycle. Its source lookup reads the live map. A destination draws the lowest free physical tag. When the instruction is marked as a speculative branch, a snapshot of the map is written into a free shadow slot. That snapshot already holds the instruction's own destination update. From then on, the slot records every physical tag handed out while it is live.

When a branch resolves as mispredicted, the whole map is reloaded from its slot in one clock edge. Every tag the slot recorded goes back to the free set. The slot and all slots taken after it are discarded. When a branch resolves correctly, only its own slot is released. The retire side returns the superseded tags of committed instructions through a release port.

Each shadow slot is a two-state machine. SLOT_FREE moves to SLOT_LIVE on the TAKE transition, when a branch is renamed and this is the lowest-numbered free slot. SLOT_LIVE returns to SLOT_FREE on one of two transitions. COMMIT happens when this slot resolves correctly. SQUASH happens when this slot, or an older live slot, resolves as mispredicted. Relative age between live slots is kept in an age matrix that is written on every TAKE.

Top module: `rmt_ckpt_top`

## Requirements
- R1: After reset, architectural register a maps to physical tag a, tags NUM_ARCH to NUM_PHYS-1 are free, and every slot is in SLOT_FREE.
- R2: `src_tag` shows the current mapping of `src_arch` in the same cycle. An accepted rename with a destination changes that mapping to `ren_tag` from the next cycle on.
- R3: `ren_tag` is the lowest-numbered free tag. Once the rename is accepted, that tag is no longer free.
- R4: A tag returned on `rel_tag` with `rel_valid` high is free from the next cycle on.
- R5: An accepted branch rename takes the lowest-numbered free slot, reported on `ren_slot`. The snapshot holds the map including that instruction's own destination update.
- R6: `ren_ready` is low when a branch rename finds all slots live, when a destination finds no free tag, or when a mispredict on a live slot is presented in the same cycle. In that last case the rename has no effect.
- R7: A mispredict on live slot s (`res_valid`, `res_mispredict` high, `res_slot`=s) makes the map equal to slot s's snapshot in the next cycle.
- R8: On that restore, every tag allocated while slot s was live becomes free.
- R9: The restore puts slot s and every slot taken after it into SLOT_FREE. Slots taken before s stay live.
- R10: A correct resolution of live slot s frees only slot s. The map and the free set are unchanged by it.
- R11: A resolution naming a slot in SLOT_FREE has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request this cycle |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_dst | input | 3 | Destination architectural register |
| ren_branch | input | 1 | Request is a speculative branch needing a slot |
| ren_ready | output | 1 | Request is accepted this cycle |
| ren_tag | output | 4 | Physical tag given to the destination |
| ren_slot | output | 2 | Slot given to the branch |
| src_arch | input | 3 | Architectural register to look up |
| src_tag | output | 4 | Current mapping of src_arch |
| res_valid | input | 1 | Branch resolution this cycle |
| res_slot | input | 2 | Slot of the resolving branch |
| res_mispredict | input | 1 | Resolution is a misprediction |
| rel_valid | input | 1 | Committed tag returned this cycle |
| rel_tag | input | 4 | Tag being returned |

## Verification
The risky overlap is a misprediction arriving in the same cycle as a rename. This covers a rename that carries a branch and a destination. The bench provokes it directly, with all four slots live, and again many times under random stimulus. It judges the result by whether `ren_ready` drops, and by whether the following cycles show the restored map through `src_tag`. It also checks that no tag from the squashed rename was consumed, because the next `ren_tag` must be the lowest tag of the repaired free set. A second overlap, a correct resolution in the same cycle as a new branch, is covered by random stimulus and checked through `ren_slot`.

// File: rtl/rmt_ckpt_pkg.sv
package rmt_ckpt_pkg;
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_LIVE = 1'b1
    } slot_state_e;
endpackage

// File: rtl/rmt_first_set.sv
// Lowest-index picker over a request vector.
module rmt_first_set #(
    parameter int W  = 8,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

    always_comb begin
        AST_PICK_IS_SET: assert (!any || req[idx]); // R3
    end
endmodule

// File: rtl/rmt_ckpt_slot.sv
// One shadow slot: state machine, map snapshot and allocated-tag mask.
module rmt_ckpt_slot
    import rmt_ckpt_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int TW       = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         take,
    input  logic                         drop,
    input  logic                         grow,
    input  logic [TW-1:0]                grow_tag,
    input  logic [NUM_ARCH-1:0][TW-1:0]  snap_in,
    output logic [NUM_ARCH-1:0][TW-1:0]  snap_q,
    output logic [NUM_PHYS-1:0]          mask_q,
    output logic                         live
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (take) state_d = SLOT_LIVE;
            SLOT_LIVE: if (drop) state_d = SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        live = (state_q == SLOT_LIVE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            mask_q <= '0;
        end else if (take) begin
            snap_q <= snap_in;
            mask_q <= '0;
        end else if (live && !drop && grow) begin
            mask_q[grow_tag] <= 1'b1;
        end
    end

    AST_TAKE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state_q == SLOT_FREE)); // R5
    AST_NO_TAKE_AND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && drop)); // R9
endmodule

// File: rtl/rmt_ckpt_top.sv
module rmt_ckpt_top #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    parameter int NUM_CKPT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ren_valid,
    input  logic                        ren_has_dst,
    input  logic [$clog2(NUM_ARCH)-1:0] ren_dst,
    input  logic                        ren_branch,
    output logic                        ren_ready,
    output logic [$clog2(NUM_PHYS)-1:0] ren_tag,
    output logic [$clog2(NUM_CKPT)-1:0] ren_slot,
    input  logic [$clog2(NUM_ARCH)-1:0] src_arch,
    output logic [$clog2(NUM_PHYS)-1:0] src_tag,
    input  logic                        res_valid,
    input  logic [$clog2(NUM_CKPT)-1:0] res_slot,
    input  logic                        res_mispredict,
    input  logic                        rel_valid,
    input  logic [$clog2(NUM_PHYS)-1:0] rel_tag
);
    localparam int TW = $clog2(NUM_PHYS);
    localparam int SW = $clog2(NUM_CKPT);

    typedef logic [NUM_ARCH-1:0][TW-1:0] map_t;

    map_t                  map_q, map_upd, map_d, restore_map;
    logic [NUM_PHYS-1:0]   free_q, free_d, restore_mask;
    logic [NUM_CKPT-1:0]   older_q [NUM_CKPT];
    map_t                  snap_vec [NUM_CKPT];
    logic [NUM_PHYS-1:0]   mask_vec [NUM_CKPT];
    logic [NUM_CKPT-1:0]   live_vec, take_vec, drop_vec, keep_vec;
    logic                  tag_any, slot_any, res_hit, flush;
    logic                  fire, dst_fire, take_fire;
    logic [TW-1:0]         alloc_tag;
    logic [SW-1:0]         new_slot;

    rmt_first_set #(.W(NUM_PHYS), .IW(TW)) u_tag_pick (
        .req(free_q), .any(tag_any), .idx(alloc_tag)
    );

    rmt_first_set #(.W(NUM_CKPT), .IW(SW)) u_slot_pick (
        .req(~live_vec), .any(slot_any), .idx(new_slot)
    );

    // Resolution handling and acceptance
    always_comb begin
        res_hit     = res_valid && live_vec[res_slot];
        flush       = res_hit && res_mispredict;
        restore_map = snap_vec[res_slot];
        restore_mask = mask_vec[res_slot];
        ren_ready   = !flush && (!ren_has_dst || tag_any) && (!ren_branch || slot_any);
        fire        = ren_valid && ren_ready;
        dst_fire    = fire && ren_has_dst;
        take_fire   = fire && ren_branch;
        ren_tag     = alloc_tag;
        ren_slot    = new_slot;
        src_tag     = map_q[src_arch];
    end

    always_comb begin
        for (int k = 0; k < NUM_CKPT; k++) begin
            take_vec[k] = take_fire && (new_slot == SW'(k));
            drop_vec[k] = res_hit && ((res_slot == SW'(k)) ||
                          (res_mispredict && live_vec[k] && older_q[res_slot][k]));
        end
        keep_vec = live_vec & ~drop_vec;
    end

    // Next map and free set
    always_comb begin
        map_upd = map_q;
        if (dst_fire) map_upd[ren_dst] = alloc_tag;
        map_d = flush ? restore_map : map_upd;

        free_d = free_q;
        if (dst_fire)  free_d[alloc_tag] = 1'b0;
        if (rel_valid) free_d[rel_tag]   = 1'b1;
        if (flush)     free_d = free_d | restore_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= TW'(a);
            for (int t = 0; t < NUM_PHYS; t++) free_q[t] <= (t >= NUM_ARCH);
        end else begin
            map_q  <= map_d;
            free_q <= free_d;
        end
    end

    // Age matrix: older_q[j][k] means slot j was taken before slot k
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NUM_CKPT; j++) older_q[j] <= '0;
        end else begin
            for (int k = 0; k < NUM_CKPT; k++) begin
                if (take_vec[k]) begin
                    for (int j = 0; j < NUM_CKPT; j++) begin
                        older_q[j][k] <= live_vec[j];
                        older_q[k][j] <= 1'b0;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_slot
        rmt_ckpt_slot #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .TW(TW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take_vec[g]),
            .drop     (drop_vec[g]),
            .grow     (dst_fire),
            .grow_tag (alloc_tag),
            .snap_in  (map_upd),
            .snap_q   (snap_vec[g]),
            .mask_q   (mask_vec[g]),
            .live     (live_vec[g])
        );
    end

    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_fire |-> free_q[ren_tag]); // R3
    AST_BRANCH_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_branch && (&live_vec)) |-> !ren_ready); // R6
    AST_RESTORE_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (map_q == $past(restore_map))); // R7
    AST_REPAIR_FREES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((free_q & $past(restore_mask)) == $past(restore_mask))); // R8
    AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((live_vec & $past(drop_vec)) == '0)); // R9
    AST_KEEP_UNDROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ((live_vec & $past(keep_vec)) == $past(keep_vec))); // R10
    AST_IGNORE_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !live_vec[res_slot] && !ren_valid && !rel_valid) |=>
            ((map_q == $past(map_q)) && (free_q == $past(free_q)))); // R11
endmodule

// File: tb/rmt_ckpt_top_tb_top.sv
module rmt_ckpt_top_tb_top;
    localparam int NA = 8;
    localparam int NP = 16;
    localparam int NC = 4;
    localparam int QN = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ren_valid = 0, ren_has_dst = 0, ren_branch = 0;
    logic [2:0] ren_dst = '0, src_arch = '0;
    logic ren_ready;
    logic [3:0] ren_tag, src_tag, rel_tag = '0;
    logic [1:0] ren_slot, res_slot = '0;
    logic res_valid = 0, res_mispredict = 0, rel_valid = 0;

    always #10 clk = ~clk;

    rmt_ckpt_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
        .ren_branch(ren_branch), .ren_ready(ren_ready), .ren_tag(ren_tag),
        .ren_slot(ren_slot), .src_arch(src_arch), .src_tag(src_tag),
        .res_valid(res_valid), .res_slot(res_slot), .res_mispredict(res_mispredict),
        .rel_valid(rel_valid), .rel_tag(rel_tag)
    );

    int total = 0;
    int bad = 0;

    // Reference state derived from the requirements
    int m_table [NA];
    bit m_free  [NP];
    bit m_live  [NC];
    bit m_older [NC][NC];
    int m_snap  [NC][NA];
    bit m_mask  [NC][NP];
    int q_tags  [QN];
    int q_head = 0, q_tail = 0;
    int q_snap  [NC];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int low_free_tag();
        for (int t = 0; t < NP; t++) if (m_free[t]) return t;
        return -1;
    endfunction

    function automatic int low_free_slot();
        for (int k = 0; k < NC; k++) if (!m_live[k]) return k;
        return -1;
    endfunction

    function automatic bit any_live();
        for (int k = 0; k < NC; k++) if (m_live[k]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < NA; a++) m_table[a] = a;
        for (int t = 0; t < NP; t++) m_free[t] = (t >= NA);
        for (int k = 0; k < NC; k++) begin
            m_live[k] = 0;
            for (int j = 0; j < NC; j++) m_older[k][j] = 0;
        end
        q_head = 0;
        q_tail = 0;
    endtask

    task automatic step(input bit rv, input bit hd, input int da, input bit br,
                        input int sa, input bit sv, input int ss, input bit mp,
                        input bit lv, input int lt, input string lbl);
        bit fl, rdy, hit;
        int et, es;
        bit drop [NC];
        bit live_pre [NC];
        @(negedge clk);
        ren_valid = rv; ren_has_dst = hd; ren_dst = 3'(da); ren_branch = br;
        src_arch = 3'(sa); res_valid = sv; res_slot = 2'(ss); res_mispredict = mp;
        rel_valid = lv; rel_tag = 4'(lt);
        #1;
        hit = sv && m_live[ss];
        fl  = hit && mp;
        et  = low_free_tag();
        es  = low_free_slot();
        rdy = !fl && (!hd || et >= 0) && (!br || es >= 0);
        chk(src_tag == 4'(m_table[sa]), lbl, int'(src_tag), m_table[sa]);
        chk(ren_ready == rdy, {lbl, " ready"}, int'(ren_ready), int'(rdy));
        if (hd && et >= 0) chk(ren_tag == 4'(et), {lbl, " tag"}, int'(ren_tag), et);
        if (br && es >= 0) chk(ren_slot == 2'(es), {lbl, " slot"}, int'(ren_slot), es);
        @(posedge clk);
        for (int k = 0; k < NC; k++) begin
            live_pre[k] = m_live[k];
            drop[k] = hit && ((k == ss) || (mp && m_live[k] && m_older[ss][k]));
        end
        if (fl) begin
            for (int a = 0; a < NA; a++) m_table[a] = m_snap[ss][a];
            for (int t = 0; t < NP; t++) if (m_mask[ss][t]) m_free[t] = 1;
            q_tail = q_snap[ss];
        end else if (rv && rdy) begin
            if (hd) begin
                q_tags[q_tail % QN] = m_table[da];
                q_tail++;
                m_free[et] = 0;
                for (int k = 0; k < NC; k++)
                    if (live_pre[k] && !drop[k]) m_mask[k][et] = 1;
                m_table[da] = et;
            end
            if (br) begin
                for (int j = 0; j < NC; j++) begin
                    m_older[j][es] = live_pre[j];
                    m_older[es][j] = 0;
                end
                for (int a = 0; a < NA; a++) m_snap[es][a] = m_table[a];
                for (int t = 0; t < NP; t++) m_mask[es][t] = 0;
                m_live[es] = 1;
                q_snap[es] = q_tail;
            end
        end
        for (int k = 0; k < NC; k++) if (drop[k]) m_live[k] = 0;
        if (lv) m_free[lt] = 1;
    endtask

    task automatic idle(input int sa, input string lbl);
        step(0, 0, 0, 0, sa, 0, 0, 0, 0, 0, lbl);
    endtask

    task automatic scan_table(input string lbl);
        for (int a = 0; a < NA; a++) idle(a, lbl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        int rt;
        bit rl;
        seed = $urandom(32'h5eed_0c4b);
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset map, first free tag, first free slot
        scan_table("R1");
        step(0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R1");
        // R3 then R4: allocate tag 8, release tag 0, tag 0 is lowest again
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
        idle(0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
        step(1, 1, 1, 0, 1, 0, 0, 0, 0, 0, "R4");
        // R5: branch with own destination, snapshot includes it
        step(1, 1, 2, 1, 2, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 3, 0, 2, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 0, 1, 3, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 4, 0, 4, 0, 0, 0, 0, 0, "R5");
        step(1, 0, 0, 1, 4, 0, 0, 0, 0, 0, "R5");
        step(1, 1, 5, 1, 5, 0, 0, 0, 0, 0, "R5");
        // R6: all slots live, branch stalls
        step(1, 0, 0, 1, 5, 0, 0, 0, 0, 0, "R6");
        // R6 + R7: mispredict slot 1 together with a rename; rename dropped
        step(1, 1, 6, 1, 6, 1, 1, 1, 0, 0, "R6");
        scan_table("R7");
        // R8: reclaimed tags are lowest free again
        step(1, 1, 7, 0, 7, 0, 0, 0, 0, 0, "R8");
        // R9: slots 1..3 freed, slot 0 still live, so next branch gets slot 1
        step(1, 0, 0, 1, 7, 0, 0, 0, 0, 0, "R9");
        // R11: resolving free slot 3 either way does nothing
        step(0, 0, 0, 0, 7, 1, 3, 1, 0, 0, "R11");
        step(0, 0, 0, 0, 6, 1, 3, 0, 0, 0, "R11");
        scan_table("R11");
        step(0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R11");
        // R10: correct resolution of slot 0 keeps map, frees only slot 0
        step(0, 0, 0, 0, 2, 1, 0, 0, 0, 0, "R10");
        scan_table("R10");
        step(0, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R10");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            rl = 0;
            rt = 0;
            if (!any_live() && q_head < q_tail && ($urandom % 2 == 0)) begin
                rl = 1;
                rt = q_tags[q_head % QN];
                q_head++;
            end
            step(($urandom % 4) != 0, ($urandom % 3) != 0, int'($urandom % NA),
                 ($urandom % 6) == 0, int'($urandom % NA),
                 ($urandom % 5) == 0, int'($urandom % NC), ($urandom % 2) == 0,
                 rl, rt, "R2");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule